// File: doc/BRIEF.md
# Two-Clock Dual-Port RAM with Per-Signal Staging

The block is a simple dual-port memory. One port only writes: a write enable, a write address, a data word and a byte-lane mask. The other port only reads: a read enable, a read address and the read word. An input clock drives the write side. An output clock can drive the read side. An asynchronous clear works across both sides. The block can sit on a clock-domain boundary, or both clocks can be tied together for single-clock use.

Every port signal passes through its own stage, and a parameter picks what that stage is. The write-side signals can each be a direct path or a register on the input clock. The read address and read enable can each be direct, a register on the input clock or a register on the output clock. The read word can be direct or a register on the output clock. Each register has its own flag that says whether the clear resets it. When the clocks are shared and the read word is registered, a parameter decides what a read returns when it hits the address being written in the same edge.

Top module: `tc_dpram`

## Requirements
- R1: `NUM_WORDS` must satisfy 2^(ADDR_W-1) < NUM_WORDS <= 2^ADDR_W and defaults to 2^ADDR_W. Addresses 0 to NUM_WORDS-1 are storage locations.
- R2: A write to an address at or above `NUM_WORDS` changes no location. A read from such an address returns zero.
- R3: The memory is written on a rising edge of `iclk` whenever the enable at the output of the write-enable stage is high. A registered write stage delays its signal by one `iclk` edge. A direct stage does not delay it.
- R4: Byte lane i is bits [i*BYTE_W +: BYTE_W] of the word, and it is written only when bit i of `wr_be` is 1. `BYTE_W` is 5, 8, 9 or 10, and `DATA_W` is a multiple of it.
- R5: The read address and read enable stages are each direct, registered on `iclk`, or registered on `oclk`. With every read stage direct, `q` shows the stored word at `rd_addr` combinationally.
- R6: A registered `q` loads the addressed word on an `oclk` edge when the staged read enable is 1. Otherwise it holds its value.
- R7: The staged read enable gates only the last register on the read path: the `q` register if there is one, otherwise the read-address register. With no read register, `rd_en` has no effect on `q`.
- R8: `aclr` at 1 clears every memory location to zero at once. It also clears every stage register whose clear flag is 1. A register whose clear flag is 0 keeps its value while `aclr` is 1.
- R9: Same-address rule NEW_DATA (SHARED_CLK=1, `q` registered): a read and a write on the same edge to the same in-range address give `q` the word after the byte-lane merge.
- R10: Same-address rule OLD_DATA gives `q` the word as it was before that write. DONT_CARE leaves `q` unspecified for that edge. Both rules apply only with SHARED_CLK=1 and a registered `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk | input | 1 | Input (write) clock |
| oclk | input | 1 | Output (read) clock |
| aclr | input | 1 | Asynchronous clear, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/BYTE_W | Byte-lane write mask |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| q | output | DATA_W | Read word |

## Verification
Some properties are checked on every cycle. Each stage register loads its input when enabled and holds when not. A register with its clear flag set reads zero while the clear is high. A read outside the word range returns zero. A full-mask write leaves exactly the written word at its address. The same-address rule is checked on every colliding edge: merged word for NEW_DATA, prior word for OLD_DATA.

Other behaviour shows only in the bench's scenarios. These are the one-edge offset between a registered and a direct write path, and byte-lane masks written in turn. They also cover `rd_en` being ignored when nothing on the read path is registered, and a clear that wipes memory while an unflagged `q` register keeps its word.

// File: rtl/tcdp_pkg.sv
package tcdp_pkg;
  // where a port signal is captured
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ICLK = 2'd1,
    SEL_OCLK = 2'd2
  } stage_sel_e;

  // same-address read while writing, single clock
  typedef enum logic [1:0] {
    RDW_DONT_CARE = 2'd0,
    RDW_OLD_DATA  = 2'd1,
    RDW_NEW_DATA  = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/tcdp_stage.sv
module tcdp_stage
  import tcdp_pkg::*;
#(
  parameter int         W      = 8,
  parameter stage_sel_e SEL    = SEL_ICLK,
  parameter bit         CLR_EN = 1'b1
) (
  input  logic         iclk,
  input  logic         oclk,
  input  logic         aclr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic unused_stage;
  assign unused_stage = ^{iclk, oclk, aclr, ld};

  generate
    if (SEL == SEL_NONE) begin : g_pass
      assign q = d;
    end else begin : g_reg
      logic         clk;
      logic [W-1:0] r;
      assign clk = (SEL == SEL_OCLK) ? oclk : iclk;

      if (CLR_EN) begin : g_clr
        always_ff @(posedge clk or posedge aclr) begin
          if (aclr)    r <= '0;
          else if (ld) r <= d;
        end
        assert_clear_R8: assert property (@(posedge clk) aclr |-> (r == '0));
      end else begin : g_keep
        initial r = '0;
        always_ff @(posedge clk) begin
          if (ld) r <= d;
        end
      end

      assert_load_R6: assert property (@(posedge clk) disable iff (aclr)
        ld |=> (r == $past(d)));
      assert_hold_R6: assert property (@(posedge clk) disable iff (aclr)
        !ld |=> $stable(r));

      assign q = r;
    end
  endgenerate
endmodule

// File: rtl/tcdp_array.sv
module tcdp_array #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int NUM_WORDS = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                      iclk,
  input  logic                      aclr,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         wa,
  input  logic [DATA_W-1:0]         wd,
  input  logic [DATA_W/BYTE_W-1:0]  be,
  input  logic [ADDR_W-1:0]         ra,
  output logic [DATA_W-1:0]         rdata,
  output logic                      wr_hit,
  output logic [DATA_W-1:0]         wr_word
);
  localparam int              LANES = DATA_W / BYTE_W;
  localparam logic [ADDR_W:0] NW_L  = (ADDR_W + 1)'(NUM_WORDS);

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return ({1'b0, a} < NW_L);
  endfunction

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  mask);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [DATA_W-1:0] cur_word;

  assign wr_hit   = we && in_range(wa);
  assign cur_word = in_range(wa) ? mem[wa] : '0;
  assign wr_word  = lane_merge(cur_word, wd, be);
  assign rdata    = in_range(ra) ? mem[ra] : '0;

  always_ff @(posedge iclk or posedge aclr) begin
    if (aclr) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wa] <= wr_word;
    end
  end

  assert_oob_read_R2: assert property (@(posedge iclk) disable iff (aclr)
    !in_range(ra) |-> (rdata == '0));
  assert_fullwrite_R4: assert property (@(posedge iclk) disable iff (aclr)
    (wr_hit && (&be)) |=> (mem[$past(wa)] == $past(wd)));
endmodule

// File: rtl/tc_dpram.sv
module tc_dpram
  import tcdp_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 4,
  parameter int         NUM_WORDS  = 2 ** ADDR_W,
  parameter int         BYTE_W     = 8,
  parameter stage_sel_e WA_SEL     = SEL_ICLK,
  parameter stage_sel_e WE_SEL     = SEL_ICLK,
  parameter stage_sel_e WD_SEL     = SEL_ICLK,
  parameter stage_sel_e RA_SEL     = SEL_OCLK,
  parameter stage_sel_e RE_SEL     = SEL_OCLK,
  parameter stage_sel_e Q_SEL      = SEL_NONE,
  parameter bit         WA_CLR     = 1'b1,
  parameter bit         WE_CLR     = 1'b1,
  parameter bit         WD_CLR     = 1'b1,
  parameter bit         RA_CLR     = 1'b1,
  parameter bit         RE_CLR     = 1'b1,
  parameter bit         Q_CLR      = 1'b1,
  parameter rdw_mode_e  RDW_MODE   = RDW_DONT_CARE,
  parameter bit         SHARED_CLK = 1'b0
) (
  input  logic                     iclk,
  input  logic                     oclk,
  input  logic                     aclr,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/BYTE_W-1:0] wr_be,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        q
);
  localparam int BE_W       = DATA_W / BYTE_W;
  localparam bit Q_IS_REG   = (Q_SEL != SEL_NONE);
  localparam bit RDW_ACTIVE = SHARED_CLK && Q_IS_REG;

  generate
    if (NUM_WORDS <= 2 ** (ADDR_W - 1) || NUM_WORDS > 2 ** ADDR_W) begin : g_bad_depth
      $error("tc_dpram: NUM_WORDS outside its legal range");
    end
    if (!(BYTE_W == 5 || BYTE_W == 8 || BYTE_W == 9 || BYTE_W == 10) ||
        (DATA_W % BYTE_W) != 0) begin : g_bad_lane
      $error("tc_dpram: illegal byte lane width");
    end
    if (Q_SEL == SEL_ICLK) begin : g_bad_q
      $error("tc_dpram: read word register may only use the output clock");
    end
  endgenerate

  // staged signals
  logic                 we_s, re_s;
  logic [ADDR_W-1:0]    wa_s, ra_s;
  logic [DATA_W-1:0]    wd_s;
  logic [BE_W-1:0]      be_s;
  logic [DATA_W+BE_W-1:0] wdbe_s;
  logic                 ra_ld;

  // array events
  logic [DATA_W-1:0] rdata, wr_word, q_d;
  logic              wr_hit, collide;

  tcdp_stage #(.W(1), .SEL(WE_SEL), .CLR_EN(WE_CLR)) u_we (
    .iclk(iclk), .oclk(oclk), .aclr(aclr), .ld(1'b1), .d(wr_en), .q(we_s));
  tcdp_stage #(.W(ADDR_W), .SEL(WA_SEL), .CLR_EN(WA_CLR)) u_wa (
    .iclk(iclk), .oclk(oclk), .aclr(aclr), .ld(1'b1), .d(wr_addr), .q(wa_s));
  tcdp_stage #(.W(DATA_W + BE_W), .SEL(WD_SEL), .CLR_EN(WD_CLR)) u_wd (
    .iclk(iclk), .oclk(oclk), .aclr(aclr), .ld(1'b1), .d({wr_be, wr_data}), .q(wdbe_s));
  assign {be_s, wd_s} = wdbe_s;

  tcdp_stage #(.W(1), .SEL(RE_SEL), .CLR_EN(RE_CLR)) u_re (
    .iclk(iclk), .oclk(oclk), .aclr(aclr), .ld(1'b1), .d(rd_en), .q(re_s));

  // read enable gates the last register of the read path
  assign ra_ld = Q_IS_REG ? 1'b1 : re_s;

  tcdp_stage #(.W(ADDR_W), .SEL(RA_SEL), .CLR_EN(RA_CLR)) u_ra (
    .iclk(iclk), .oclk(oclk), .aclr(aclr), .ld(ra_ld), .d(rd_addr), .q(ra_s));

  tcdp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .BYTE_W(BYTE_W)) u_mem (
    .iclk(iclk), .aclr(aclr), .we(we_s), .wa(wa_s), .wd(wd_s), .be(be_s), .ra(ra_s),
    .rdata(rdata), .wr_hit(wr_hit), .wr_word(wr_word));

  assign collide = wr_hit && (wa_s == ra_s);
  assign q_d = (RDW_ACTIVE && RDW_MODE == RDW_NEW_DATA && collide) ? wr_word : rdata;

  tcdp_stage #(.W(DATA_W), .SEL(Q_SEL), .CLR_EN(Q_CLR)) u_q (
    .iclk(iclk), .oclk(oclk), .aclr(aclr), .ld(re_s), .d(q_d), .q(q));

  generate
    if (RDW_ACTIVE && RDW_MODE == RDW_NEW_DATA) begin : g_chk_new
      assert_rdw_new_R9: assert property (@(posedge oclk) disable iff (aclr)
        (collide && re_s) |=> (q == $past(wr_word)));
    end
    if (RDW_ACTIVE && RDW_MODE == RDW_OLD_DATA) begin : g_chk_old
      assert_rdw_old_R10: assert property (@(posedge oclk) disable iff (aclr)
        (collide && re_s) |=> (q == $past(rdata)));
    end
  endgenerate
endmodule

// File: tb/tc_dpram_test.sv
module tc_dpram_test;
  import tcdp_pkg::*;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NW = 12;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic aclr = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    wr_be = '0;
  logic [DW-1:0] q_a, q_b, q_c;

  always #4 clk = ~clk;

  // all staged, NEW_DATA on a shared clock
  tc_dpram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .BYTE_W(BW),
    .WA_SEL(SEL_ICLK), .WE_SEL(SEL_ICLK), .WD_SEL(SEL_ICLK),
    .RA_SEL(SEL_OCLK), .RE_SEL(SEL_OCLK), .Q_SEL(SEL_OCLK),
    .RDW_MODE(RDW_NEW_DATA), .SHARED_CLK(1'b1)) uut (
    .iclk(clk), .oclk(clk), .aclr(aclr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .q(q_a));

  // fully direct
  tc_dpram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .BYTE_W(BW),
    .WA_SEL(SEL_NONE), .WE_SEL(SEL_NONE), .WD_SEL(SEL_NONE),
    .RA_SEL(SEL_NONE), .RE_SEL(SEL_NONE), .Q_SEL(SEL_NONE)) uut_b (
    .iclk(clk), .oclk(clk), .aclr(aclr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .q(q_b));

  // direct inputs, q registered without clear, OLD_DATA
  tc_dpram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .BYTE_W(BW),
    .WA_SEL(SEL_NONE), .WE_SEL(SEL_NONE), .WD_SEL(SEL_NONE),
    .RA_SEL(SEL_NONE), .RE_SEL(SEL_NONE), .Q_SEL(SEL_OCLK), .Q_CLR(1'b0),
    .RDW_MODE(RDW_OLD_DATA), .SHARED_CLK(1'b1)) uut_c (
    .iclk(clk), .oclk(clk), .aclr(aclr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .q(q_c));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [DW-1:0] mem_s [NW];   // staged instance
  logic [DW-1:0] mem_d [NW];   // direct-write instances
  logic          m_we, m_re;
  logic [AW-1:0] m_wa, m_ra;
  logic [DW-1:0] m_wd, exp_a, exp_c;
  logic [1:0]    m_be;

  function automatic bit legal(input logic [AW-1:0] a);
    return int'(a) < NW;
  endfunction

  function automatic logic [DW-1:0] apply_mask(input logic [DW-1:0] base,
                                               input logic [DW-1:0] nd,
                                               input logic [1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = m[b / BW] ? nd[b] : base[b];
    return r;
  endfunction

  function automatic logic [DW-1:0] peek_s(input logic [AW-1:0] a);
    return legal(a) ? mem_s[a] : '0;
  endfunction

  function automatic logic [DW-1:0] peek_d(input logic [AW-1:0] a);
    return legal(a) ? mem_d[a] : '0;
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a negedge; ends at the next negedge
  task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [1:0] be, input logic re, input logic [AW-1:0] ra,
                      input string tag);
    logic [DW-1:0] nq;
    check(q_a, exp_a, {tag, " staged q (R3 R6 R9)"});
    check(q_c, exp_c, {tag, " registered q (R6 R10)"});
    wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be; rd_en = re; rd_addr = ra;
    #1;
    check(q_b, peek_d(ra), {tag, " direct q (R5 R7)"});
    // staged instance: read then write at the coming edge
    nq = exp_a;
    if (m_re) begin
      nq = peek_s(m_ra);
      if (m_we && legal(m_wa) && m_wa == m_ra) nq = apply_mask(nq, m_wd, m_be);
    end
    if (m_we && legal(m_wa)) mem_s[m_wa] = apply_mask(mem_s[m_wa], m_wd, m_be);
    exp_a = nq;
    m_we = we; m_wa = wa; m_wd = wd; m_be = be; m_re = re; m_ra = ra;
    // direct-write instances: old word on collision
    if (re) exp_c = peek_d(ra);
    if (we && legal(wa)) mem_d[wa] = apply_mask(mem_d[wa], wd, be);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_pulse(input logic [AW-1:0] probe);
    wr_en = 1'b0; rd_en = 1'b0; rd_addr = probe; wr_be = '0;
    aclr = 1'b1;
    #1;
    for (int i = 0; i < NW; i++) begin mem_s[i] = '0; mem_d[i] = '0; end
    m_we = 0; m_re = 0; m_wa = '0; m_ra = '0; m_wd = '0; m_be = '0; exp_a = '0;
    check(q_a, '0, "R8 flagged q cleared at once");
    check(q_c, exp_c, "R8 unflagged q keeps value");
    check(q_b, '0, "R8 memory cleared");
    @(posedge clk);
    @(negedge clk);
    check(q_c, exp_c, "R8 unflagged q keeps value across edge");
    aclr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin mem_s[i] = '0; mem_d[i] = '0; end
    m_we = 0; m_re = 0; m_wa = '0; m_ra = '0; m_wd = '0; m_be = '0;
    exp_a = '0; exp_c = '0;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check(q_a, '0, "R8 reset q");
    check(q_b, '0, "R8 reset contents");
    aclr = 1'b0;

    // R3: staged write lands one edge later than direct write
    step(1, 4'd3, 16'hA1B2, 2'b11, 1, 4'd3, "R3 write");
    check(q_b, 16'hA1B2, "R3 direct write visible after one edge");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd3, "R3 readback");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd3, "R3 readback");
    check(q_a, 16'hA1B2, "R3 staged readback");

    // R4: byte lanes one at a time
    step(1, 4'd5, 16'h1111, 2'b11, 0, 4'd5, "R4 base");
    step(1, 4'd5, 16'hEEEE, 2'b01, 0, 4'd5, "R4 low lane");
    step(1, 4'd5, 16'h7777, 2'b10, 1, 4'd5, "R4 high lane");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd5, "R4 readback");
    check(q_b, 16'h77EE, "R4 merged lanes");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd5, "R4 readback");

    // R1, R2: last legal word and the words past it
    step(1, 4'd11, 16'hC0DE, 2'b11, 1, 4'd11, "R1 top word");
    step(1, 4'd12, 16'hDEAD, 2'b11, 1, 4'd12, "R2 write past end");
    step(1, 4'd15, 16'hBEEF, 2'b11, 1, 4'd15, "R2 write past end");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd11, "R1 top word readback");
    check(q_b, 16'hC0DE, "R1 word NUM_WORDS-1 stored");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd12, "R2 read past end");
    check(q_b, '0, "R2 read past end is zero");

    // R6 hold, R7 rd_en ignored on a direct read path
    step(0, 4'd0, 16'h0, 2'b00, 0, 4'd3, "R6 R7 read disabled");
    step(0, 4'd0, 16'h0, 2'b00, 0, 4'd11, "R6 R7 read disabled");
    check(q_b, 16'hC0DE, "R7 rd_en low still reads");
    step(0, 4'd0, 16'h0, 2'b00, 0, 4'd5, "R6 hold");

    // R9 R10: same-address collisions
    step(1, 4'd7, 16'h5A5A, 2'b11, 1, 4'd7, "R9 R10 collide");
    step(1, 4'd7, 16'hFF00, 2'b10, 1, 4'd7, "R9 R10 collide");
    step(1, 4'd7, 16'h00FF, 2'b01, 1, 4'd7, "R9 R10 collide");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd7, "R9 R10 after");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd7, "R9 R10 after");

    // R8: clear mid-run
    clear_pulse(4'd7);
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd7, "R8 after clear");
    step(0, 4'd0, 16'h0, 2'b00, 1, 4'd3, "R8 after clear");

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [AW-1:0] wa, ra;
      wa = AW'($urandom % 16);
      ra = ($urandom % 3 == 0) ? wa : AW'($urandom % 16);
      step(1'($urandom % 2), wa, 16'($urandom), 2'($urandom % 4),
           1'(($urandom % 4) != 0), ra, "R2 R3 R4 R6 R9 R10 random");
    end
    step(0, 4'd0, 16'h0, 2'b00, 0, 4'd0, "final");

    done = 1'b1;
    finish_run();
  end
endmodule